// File: doc/BRIEF.md
# Power-Good Fault Supervisor

This block watches the output rails of a multi-rail power manager. There are three switching converters and four linear regulators. The block raises two active-high power-good outputs, and it latches a request to shut down every rail once any monitored fault appears.

Each rail has an enable bit and a fault flag. A fault flag only counts while its rail is enabled. Three other conditions also count as faults:
- an over-temperature flag;
- an undervoltage lockout, found by comparing an 8-bit sampled input-voltage code with one of four thresholds picked by a 2-bit setting;
- a dropout condition on any enabled linear regulator whose output setting comes within a fixed margin of the input code.

When any fault is present, the shutdown latch sets and both good outputs fall together. The latch stays set until a power-cycle request arrives while no fault is present. A reset also clears it.

Top module: `pg_supervisor`

## Requirements
- R1: `pg_pri` reflects the primary group, which is rail indices 0, 1, 2 (converters 1 to 3) and 5, 6 (linear regulators 3 and 4). After a clock edge it is 1 exactly when at least one rail of that group is enabled and the shutdown latch is clear after that edge.
- R2: `pg_sec` reflects the secondary group, which is rail indices 3 and 4 (linear regulators 1 and 2). After a clock edge it is 1 exactly when at least one of those two rails is enabled and the shutdown latch is clear after that edge.
- R3: A fault flag on a rail whose enable bit is 0 has no effect. A dropout condition on a disabled linear regulator also has no effect.
- R4: Any of these sets `shutdown` and drives both good outputs to 0 on the next clock edge: a fault flag on an enabled rail, `ot_flag` high, or undervoltage lockout.
- R5: Undervoltage lockout holds while `vin_code` is below the threshold picked by `uvlo_sel`. The thresholds are 137 for code 0, 145 for code 1, 159 for code 2 and 168 for code 3 (20 mV per code step).
- R6: Linear regulator k (rail index 3+k) is in dropout when `vin_code` is below its setting code plus 10. The setting code is `ldo_set[8k+7:8k]`.
- R7: `shutdown` stays at 1 until an edge where `pwr_cycle` is 1 and no fault is present, and it reads 0 after that edge. If a fault is present at that edge, it stays at 1.
- R8: While `rst_n` is 0, all three outputs read 0 after each clock edge.
- R9: A group with no enabled rail keeps its good output at 0, even when no fault is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rail_en | input | 7 | Per-rail enable, indices 0-2 converters, 3-6 linear regulators 1-4 |
| rail_flt | input | 7 | Per-rail fault flag (short or regulation loss) |
| ot_flag | input | 1 | Over-temperature condition |
| vin_code | input | 8 | Sampled input-voltage code |
| uvlo_sel | input | 2 | Lockout threshold select |
| ldo_set | input | 32 | Output setting codes of the four linear regulators, 8 bits each |
| pwr_cycle | input | 1 | Request to clear the shutdown latch |
| pg_pri | output | 1 | Primary power-good |
| pg_sec | output | 1 | Secondary power-good |
| shutdown | output | 1 | Latched request to shut down all rails |

## Verification
The bench runs every enable pattern against every single-rail fault, so it exposes four kinds of error:
- a wrong group mask, which shows up as the wrong good output falling or staying high;
- a fault that is not gated by its enable;
- a group with no enabled rail that still reports good;
- a fault that drops only its own group instead of collapsing both.

For every threshold select, the input code is swept across the lockout boundary, so a threshold that is off by one or uses `<=` instead of `<` changes the result exactly at the edge code. Dropout gets the same boundary sweep for each regulator, and the sweep covers the wrap near the top of the code range, where an adder that is too narrow would overflow. The latch is tested in three ways: faults are removed without a power-cycle, a power-cycle is issued while a fault persists, and a power-cycle is issued once the fault is gone. A latch that clears on its own, or that lets a power-cycle override a live fault, therefore fails.

// File: rtl/pgs_pkg.sv
// Package: shared constants for the power-good supervisor.
// Assumes rail order: converters first, then linear regulators 1..4.
package pgs_pkg;
    localparam int N_CONV = 3;
    localparam int N_LDO  = 4;
    localparam int N_RAIL = N_CONV + N_LDO;
    localparam int CODE_W = 8;

    // Primary group: converters 1-3 and regulators 3-4; secondary: regulators 1-2
    localparam logic [N_RAIL-1:0] PRI_MASK = 7'b110_0111;
    localparam logic [N_RAIL-1:0] SEC_MASK = 7'b001_1000;

    // Lockout thresholds in input codes (20 mV per step)
    localparam logic [CODE_W-1:0] UV_TH0 = 8'd137;
    localparam logic [CODE_W-1:0] UV_TH1 = 8'd145;
    localparam logic [CODE_W-1:0] UV_TH2 = 8'd159;
    localparam logic [CODE_W-1:0] UV_TH3 = 8'd168;

    // Dropout margin of a linear regulator in input codes
    localparam logic [CODE_W-1:0] DROP_CODE = 8'd10;
endpackage

// File: rtl/pgs_uvlo_cmp.sv
// Module: undervoltage-lockout comparator.
// Picks one of four thresholds by a 2-bit select and flags an input code
// strictly below it. Purely combinational.
module pgs_uvlo_cmp #(
    parameter int               CODE_W = 8,
    parameter logic [CODE_W-1:0] TH0   = 8'd137,
    parameter logic [CODE_W-1:0] TH1   = 8'd145,
    parameter logic [CODE_W-1:0] TH2   = 8'd159,
    parameter logic [CODE_W-1:0] TH3   = 8'd168
) (
    input  logic [CODE_W-1:0] vin_code,
    input  logic [1:0]        sel,
    output logic              uvlo
);
    logic [CODE_W-1:0] thr;

    // Select the active threshold and compare against it
    always_comb begin
        case (sel)
            2'd0:    thr = TH0;
            2'd1:    thr = TH1;
            2'd2:    thr = TH2;
            default: thr = TH3;
        endcase
        uvlo = (vin_code < thr);
    end
endmodule

// File: rtl/pgs_dropout_chk.sv
// Module: per-regulator dropout detector.
// Flags regulator k when the input code is below its setting plus the
// dropout margin. Uses one extra bit so the sum cannot wrap.
module pgs_dropout_chk #(
    parameter int                N_LDO  = 4,
    parameter int                CODE_W = 8,
    parameter logic [CODE_W-1:0] MARGIN = 8'd10
) (
    input  logic [CODE_W-1:0]       vin_code,
    input  logic [N_LDO*CODE_W-1:0] ldo_set,
    output logic [N_LDO-1:0]        drop
);
    localparam logic [CODE_W:0] MARGIN_X = {1'b0, MARGIN};

    for (genvar k = 0; k < N_LDO; k++) begin : g_ldo
        logic [CODE_W:0] limit;
        // Compare the widened input code with setting plus margin
        always_comb begin
            limit   = {1'b0, ldo_set[k*CODE_W +: CODE_W]} + MARGIN_X;
            drop[k] = ({1'b0, vin_code} < limit);
        end
    end
endmodule

// File: rtl/pgs_fault_latch.sv
// Module: shutdown latch and registered good outputs.
// Assumes fault_now is already gated by the rail enables. The latch sets on
// any fault, and clears only on a power-cycle with no fault present.
module pgs_fault_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic fault_now,
    input  logic pwr_cycle,
    input  logic pri_any,
    input  logic sec_any,
    output logic shutdown,
    output logic pg_pri,
    output logic pg_sec
);
    logic shut_d;

    // Next latch state: a fault sets it, a power-cycle releases it
    always_comb shut_d = fault_now | (shutdown & ~pwr_cycle);

    // Register the latch and both good outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shutdown <= 1'b0;
            pg_pri   <= 1'b0;
            pg_sec   <= 1'b0;
        end else begin
            shutdown <= shut_d;
            pg_pri   <= ~shut_d & pri_any;
            pg_sec   <= ~shut_d & sec_any;
        end
    end

    p_latch_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (shutdown && !pwr_cycle) |=> shutdown);

    p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (shutdown && pwr_cycle && !fault_now) |=> !shutdown);

    p_good_low_when_shut_r4: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown |-> (!pg_pri && !pg_sec));
endmodule

// File: rtl/pg_supervisor.sv
// Module: power-good fault supervisor top.
// Combines enable-gated rail faults, regulator dropout, over-temperature and
// undervoltage lockout into one fault term that feeds the shutdown latch.
// Assumes all inputs are synchronous to clk.
module pg_supervisor
    import pgs_pkg::*;
#(
    parameter int NUM_CONV = N_CONV,
    parameter int NUM_LDO  = N_LDO,
    parameter int VCODE_W  = CODE_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [6:0]                  rail_en,
    input  logic [6:0]                  rail_flt,
    input  logic                        ot_flag,
    input  logic [VCODE_W-1:0]          vin_code,
    input  logic [1:0]                  uvlo_sel,
    input  logic [NUM_LDO*VCODE_W-1:0]  ldo_set,
    input  logic                        pwr_cycle,
    output logic                        pg_pri,
    output logic                        pg_sec,
    output logic                        shutdown
);
    localparam int RAILS = NUM_CONV + NUM_LDO;

    logic [NUM_LDO-1:0] ldo_drop;
    logic [RAILS-1:0]   rail_bad;
    logic               uvlo;
    logic               fault_now;
    logic               pri_any;
    logic               sec_any;

    pgs_uvlo_cmp #(
        .CODE_W (VCODE_W),
        .TH0    (UV_TH0),
        .TH1    (UV_TH1),
        .TH2    (UV_TH2),
        .TH3    (UV_TH3)
    ) u_uvlo (
        .vin_code (vin_code),
        .sel      (uvlo_sel),
        .uvlo     (uvlo)
    );

    pgs_dropout_chk #(
        .N_LDO  (NUM_LDO),
        .CODE_W (VCODE_W),
        .MARGIN (DROP_CODE)
    ) u_drop (
        .vin_code (vin_code),
        .ldo_set  (ldo_set),
        .drop     (ldo_drop)
    );

    // Gate per-rail faults by enables and merge global fault sources
    always_comb begin
        rail_bad  = (rail_flt | {ldo_drop, {NUM_CONV{1'b0}}}) & rail_en;
        fault_now = (|rail_bad) | ot_flag | uvlo;
        pri_any   = |(rail_en & PRI_MASK);
        sec_any   = |(rail_en & SEC_MASK);
    end

    pgs_fault_latch u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .fault_now (fault_now),
        .pwr_cycle (pwr_cycle),
        .pri_any   (pri_any),
        .sec_any   (sec_any),
        .shutdown  (shutdown),
        .pg_pri    (pg_pri),
        .pg_sec    (pg_sec)
    );

    p_ot_shut_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ot_flag |=> (shutdown && !pg_pri && !pg_sec));

    p_pri_needs_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rail_en[0] | rail_en[1] | rail_en[2] | rail_en[5] | rail_en[6]) == 1'b0
        |=> !pg_pri);

    p_sec_needs_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rail_en[3] | rail_en[4]) == 1'b0 |=> !pg_sec);

    p_dis_flt_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!shutdown && rail_en == 7'd0 && !ot_flag && !uvlo) |=> !shutdown);
endmodule

// File: tb/tb_pg_supervisor.sv
module tb_pg_supervisor;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  rail_en = '0;
    logic [6:0]  rail_flt = '0;
    logic        ot_flag = 1'b0;
    logic [7:0]  vin_code = 8'd200;
    logic [1:0]  uvlo_sel = 2'd0;
    logic [31:0] ldo_set = '0;
    logic        pwr_cycle = 1'b0;
    logic        pg_pri, pg_sec, shutdown;

    int n_chk = 0;
    int n_fail = 0;
    logic m_shut = 1'b0;
    logic m_pri = 1'b0;
    logic m_sec = 1'b0;
    bit done = 0;

    always #4 clk = ~clk;

    pg_supervisor dut (
        .clk(clk), .rst_n(rst_n), .rail_en(rail_en), .rail_flt(rail_flt),
        .ot_flag(ot_flag), .vin_code(vin_code), .uvlo_sel(uvlo_sel),
        .ldo_set(ldo_set), .pwr_cycle(pwr_cycle),
        .pg_pri(pg_pri), .pg_sec(pg_sec), .shutdown(shutdown)
    );

    function automatic logic fault_model();
        int th;
        logic f;
        case (uvlo_sel)
            2'd0: th = 137;
            2'd1: th = 145;
            2'd2: th = 159;
            default: th = 168;
        endcase
        f = ot_flag || (int'(vin_code) < th) || ((rail_flt & rail_en) != 0);
        for (int k = 0; k < 4; k++)
            if (rail_en[3+k] && int'(vin_code) < int'(ldo_set[8*k +: 8]) + 10) f = 1'b1;
        return f;
    endfunction

    task automatic chk(string req, logic act, logic exp, string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    // One clock edge: update model from pre-edge inputs, then compare outputs
    task automatic step(string req);
        logic f;
        f = fault_model();
        @(posedge clk);
        if (!rst_n) begin
            m_shut = 0; m_pri = 0; m_sec = 0;
        end else begin
            m_shut = f | (m_shut & ~pwr_cycle);
            m_pri  = ~m_shut & (rail_en[0] | rail_en[1] | rail_en[2] | rail_en[5] | rail_en[6]);
            m_sec  = ~m_shut & (rail_en[3] | rail_en[4]);
        end
        #1;
        chk(req, shutdown, m_shut, "shutdown");
        chk(req, pg_pri, m_pri, "pg_pri");
        chk(req, pg_sec, m_sec, "pg_sec");
    endtask

    // Clear the latch with a clean, fault-free power-cycle
    task automatic clean();
        rail_flt = '0; ot_flag = 0; vin_code = 8'd200; uvlo_sel = 2'd0;
        ldo_set = '0; pwr_cycle = 1; rail_en = 7'h7F;
        step("R7");
        pwr_cycle = 0;
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        // R8: reset holds outputs low even with faults and enables present
        rail_en = 7'h7F; ot_flag = 1;
        step("R8"); step("R8");
        ot_flag = 0;
        step("R8");
        rst_n = 1;
        // R1 R2 R3 R4 R9: every enable pattern against every single-rail fault
        for (int en = 0; en < 128; en++) begin
            for (int fb = -1; fb < 7; fb++) begin
                clean();
                rail_en = 7'(en);
                rail_flt = (fb < 0) ? 7'd0 : 7'(1 << fb);
                step((fb >= 0 && !en[fb]) ? "R3" : (fb >= 0 ? "R4" : "R1 R2 R9"));
            end
        end
        // R4: over-temperature with all rails disabled
        clean(); rail_en = '0; ot_flag = 1; step("R4");
        // R5: lockout boundary sweep per threshold select
        for (int s = 0; s < 4; s++) begin
            for (int v = 125; v < 180; v++) begin
                clean();
                uvlo_sel = 2'(s); vin_code = 8'(v);
                step("R5");
            end
        end
        // R6 R3: dropout boundary per regulator, enabled and disabled
        for (int k = 0; k < 4; k++) begin
            for (int e = 0; e < 2; e++) begin
                for (int v = 170; v < 185; v++) begin
                    clean();
                    rail_en = e ? 7'h7F : ~7'(1 << (3 + k));
                    ldo_set = 32'(170) << (8 * k);
                    vin_code = 8'(v);
                    step(e ? "R6" : "R3");
                end
                // wrap corner: setting near top of the code range
                clean();
                rail_en = e ? 7'h7F : ~7'(1 << (3 + k));
                ldo_set = 32'(250) << (8 * k);
                vin_code = 8'd255;
                step(e ? "R6" : "R3");
            end
        end
        // R7: latch persistence and release ordering
        clean();
        ot_flag = 1; step("R7");
        ot_flag = 0; step("R7"); step("R7");
        ot_flag = 1; pwr_cycle = 1; step("R7");
        ot_flag = 0; step("R7");
        pwr_cycle = 0; step("R7");
        // R8: reset clears an already set latch
        ot_flag = 1; step("R7");
        ot_flag = 0; rst_n = 0; step("R8");
        rst_n = 1; step("R1");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule